// File: doc/BRIEF.md
# Quad-Channel Converter Serial Register Interface

This block is the digital front end of a four-channel, 10-bit voltage-output converter. A host talks to it over a three-wire serial link: an active-low frame strobe, a serial clock and a data line. Each frame carries a 24-bit command word. Every channel owns two registers: a staging (input) register and an output (DAC) register that drives the analog string. Codes move from staging to output either in the frame that wrote them or later, when a load strobe falls. The load strobe loads all four channels at the same instant.

A serial output pin returns data to the host. After a readback-select frame, the next frame shifts out the staging code of the chosen channel. Otherwise the pin repeats the previous frame, 24 clocks late. This lets several devices share one strobe in a chain. A power-on reset and a separate active-low reset pin clear every channel to zero scale or midscale, chosen by a select input. Each channel also has a power-down flag that leaves its codes untouched.

The serial pins are sampled by the system clock. Frame control is a three-state machine. `ST_IDLE` moves to `ST_SHIFT` on the start transition (strobe falls). `ST_SHIFT` moves to `ST_EXEC` on the complete transition (strobe rises after a full 24 bits). `ST_SHIFT` returns to `ST_IDLE` on the abort transition (strobe rises early). `ST_EXEC` returns to `ST_IDLE` on the retire transition after one cycle, and that cycle carries out the command.

Top module: `quad_dac_serial_if`

## Requirements
- R1: A frame is the bits sampled on falling serial-clock edges while `sync_n` is low, MSB first. At least 24 bits must arrive, and the last 24 received are decoded when `sync_n` rises. Bits [23:20] hold the command and bits [19:16] select channels, with bit 16 selecting channel 0 and bit 19 channel 3. Bits [15:6] hold the 10-bit code. Channel n occupies `dac_codes[10n+9:10n]`.
- R2: Command 0x1 writes the code into the staging register of every selected channel. If `ldac_n` is high when the frame completes, the output registers keep their value.
- R3: Command 0x1 completed while `ldac_n` is low also writes the code straight into the selected output registers.
- R4: Command 0x2 copies the staging register into the output register of every selected channel.
- R5: Command 0x3 writes the code into both the staging and the output register of every selected channel.
- R6: A falling edge on `ldac_n` copies all four staging registers into their output registers in the same cycle.
- R7: Command 0x4 sets the power-down flag of each selected channel when data bits [15:0] are nonzero, and clears it when they are zero. The codes of every channel are unchanged.
- R8: A frame in which `sync_n` rises after fewer than 24 falling clock edges is discarded and changes no register.
- R9: While `rst_n` or `reset_n` is low, every staging and output register is loaded with 0x000 when `rstsel` is 0, or with 0x200 when it is 1. All power-down flags are cleared.
- R10: After a command 0x9 frame, the next frame shifts out on `sdo` the word {8'h00, staging code, 6'b0} of the lowest-numbered selected channel, MSB first.
- R11: Apart from R10, `sdo` presents the 24 bits held from the previous frame. Bit 23 appears once `sync_n` falls, and each rising clock edge advances it by one bit. In a 48-clock frame, the second 24 bits out are therefore the first 24 bits in. `sdo` changes only on a frame start or a rising clock edge.
- R12: Commands other than 0x1, 0x2, 0x3, 0x4 and 0x9 change no code and no power-down flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial pins |
| rst_n | input | 1 | Power-on reset, active low |
| reset_n | input | 1 | Reset pin, active low, clears channels as R9 |
| rstsel | input | 1 | Clear value select: 0 zero scale, 1 midscale |
| sync_n | input | 1 | Frame strobe, active low |
| sclk | input | 1 | Serial clock |
| sdin | input | 1 | Serial data in |
| ldac_n | input | 1 | Load strobe, active low |
| sdo | output | 1 | Serial data out for readback and chaining |
| dac_codes | output | 40 | Four output-register codes, channel 0 in the low bits |
| pd_state | output | 4 | Power-down flag per channel |

## Verification
The assertions check several rules on every cycle. Output codes and flags move only on a command cycle, a load-strobe fall or a clear. The load-strobe fall copies staging into output. The clear and direct-write paths land the right value one cycle later. A command cycle only ever follows a full 24-bit frame, and an early strobe rise returns the state machine to idle. `sdo` holds still between frame starts and rising clock edges. The bench scenarios are what show the encodings at work. They confirm which channels a given address pattern selects, and that the code lands left-justified. They also show the readback word in the frame after the select, and the chained word emerging from the second half of a 48-clock frame.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
    localparam int FRAME_W = 24;
    localparam int CMD_W   = 4;
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = FRAME_W - CMD_W - ADDR_W;

    typedef enum logic [CMD_W-1:0] {
        CMD_NOP    = 4'h0,
        CMD_WR_IN  = 4'h1,
        CMD_UPD    = 4'h2,
        CMD_WR_UPD = 4'h3,
        CMD_PWR    = 4'h4,
        CMD_RB_SEL = 4'h9
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_EXEC
    } frame_st_e;
endpackage

// File: rtl/qdac_pin_sync.sv
module qdac_pin_sync #(
    parameter int           N    = 3,
    parameter logic [N-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pins_i,
    output logic [N-1:0] lvl_o,
    output logic [N-1:0] prv_o
);
    logic [N-1:0] s0_q, s1_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s0_q <= INIT;
            s1_q <= INIT;
        end else begin
            s0_q <= pins_i;
            s1_q <= s0_q;
        end
    end

    assign lvl_o = s0_q;
    assign prv_o = s1_q;
endmodule

// File: rtl/qdac_frame.sv
module qdac_frame
    import qdac_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sdin,
    input  logic               sclk_fall,
    input  logic               sclk_rise,
    input  logic               sync_fall,
    input  logic               sync_rise,
    input  logic               rb_load,
    input  logic [FRAME_W-1:0] rb_word,
    output logic               frame_start,
    output logic               exec,
    output logic [FRAME_W-1:0] word,
    output logic               sdo
);
    localparam int                CNT_W = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0]  FULL  = CNT_W'(FRAME_W);

    frame_st_e          st_q, st_d;
    logic [FRAME_W-1:0] sh_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               sdin_q;
    logic               sdo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (sync_fall) st_d = ST_SHIFT;
            ST_SHIFT: if (sync_rise) st_d = (cnt_q == FULL) ? ST_EXEC : ST_IDLE;
            ST_EXEC:  st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            cnt_q  <= '0;
            sdin_q <= 1'b0;
            sdo_q  <= 1'b0;
        end else begin
            sdin_q <= sdin;
            if (st_q == ST_IDLE && sync_fall) begin
                cnt_q <= '0;
                if (rb_load) begin
                    sh_q  <= rb_word;
                    sdo_q <= rb_word[FRAME_W-1];
                end else begin
                    sdo_q <= sh_q[FRAME_W-1];
                end
            end else if (st_q == ST_SHIFT) begin
                if (sclk_fall) begin
                    sh_q <= {sh_q[FRAME_W-2:0], sdin_q};
                    if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
                end else if (sclk_rise) begin
                    sdo_q <= sh_q[FRAME_W-1];
                end
            end
        end
    end

    always_comb begin
        frame_start = (st_q == ST_IDLE) && sync_fall;
        exec        = (st_q == ST_EXEC);
        word        = sh_q;
        sdo         = sdo_q;
    end

    assert_full_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_EXEC) |-> (cnt_q == FULL));

    assert_short_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SHIFT && sync_rise && cnt_q != FULL) |=> (st_q == ST_IDLE));

    assert_sdo_edges_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!(st_q == ST_SHIFT && sclk_rise) && !frame_start) |=> $stable(sdo));
endmodule

// File: rtl/qdac_channel.sv
module qdac_channel #(
    parameter int CODE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [CODE_W-1:0] clr_val,
    input  logic              load_in,
    input  logic              load_dac_direct,
    input  logic              load_dac_from_in,
    input  logic              pd_wr,
    input  logic              pd_val,
    input  logic [CODE_W-1:0] code_in,
    output logic [CODE_W-1:0] in_code,
    output logic [CODE_W-1:0] dac_code,
    output logic              pd
);
    logic [CODE_W-1:0] in_q, dac_q;
    logic              pd_q;

    always_ff @(posedge clk) begin
        if (clr) begin
            in_q  <= clr_val;
            dac_q <= clr_val;
            pd_q  <= 1'b0;
        end else begin
            if (load_in) in_q <= code_in;
            if (load_dac_direct)       dac_q <= code_in;
            else if (load_dac_from_in) dac_q <= in_q;
            if (pd_wr) pd_q <= pd_val;
        end
    end

    assign in_code  = in_q;
    assign dac_code = dac_q;
    assign pd       = pd_q;

    assert_clear_value_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (dac_code == $past(clr_val) && in_code == $past(clr_val) && !pd));

    assert_direct_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_dac_direct && !clr) |=> (dac_code == $past(code_in)));

    assert_pd_keeps_codes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_wr && !clr && !load_in && !load_dac_direct && !load_dac_from_in)
        |=> ($stable(dac_code) && $stable(in_code)));
endmodule

// File: rtl/quad_dac_serial_if.sv
module quad_dac_serial_if
    import qdac_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CODE_W = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reset_n,
    input  logic                     rstsel,
    input  logic                     sync_n,
    input  logic                     sclk,
    input  logic                     sdin,
    input  logic                     ldac_n,
    output logic                     sdo,
    output logic [NUM_CH*CODE_W-1:0] dac_codes,
    output logic [NUM_CH-1:0]        pd_state
);
    localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);
    localparam int                PAD_W    = DATA_W - CODE_W;

    logic [2:0] pin_lvl, pin_prv;
    logic       sclk_fall, sclk_rise, sync_fall, sync_rise, ldac_fall, ldac_low;

    qdac_pin_sync #(.N(3), .INIT(3'b110)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_i ({ldac_n, sync_n, sclk}),
        .lvl_o  (pin_lvl),
        .prv_o  (pin_prv)
    );

    assign sclk_fall = pin_prv[0] & ~pin_lvl[0];
    assign sclk_rise = ~pin_prv[0] & pin_lvl[0];
    assign sync_fall = pin_prv[1] & ~pin_lvl[1];
    assign sync_rise = ~pin_prv[1] & pin_lvl[1];
    assign ldac_fall = pin_prv[2] & ~pin_lvl[2];
    assign ldac_low  = ~pin_lvl[2];

    logic                     frame_start, exec;
    logic [FRAME_W-1:0]       word, rb_word;
    logic                     rb_pend_q;
    logic [NUM_CH-1:0]        rb_sel_q;
    logic [NUM_CH*CODE_W-1:0] in_codes;
    logic [CODE_W-1:0]        rb_code;

    qdac_frame u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .sdin        (sdin),
        .sclk_fall   (sclk_fall),
        .sclk_rise   (sclk_rise),
        .sync_fall   (sync_fall),
        .sync_rise   (sync_rise),
        .rb_load     (rb_pend_q),
        .rb_word     (rb_word),
        .frame_start (frame_start),
        .exec        (exec),
        .word        (word),
        .sdo         (sdo)
    );

    cmd_e               cmd;
    logic [ADDR_W-1:0]  addr;
    logic [DATA_W-1:0]  data;
    logic [CODE_W-1:0]  code;
    logic               pd_req;
    logic               clr;
    logic [CODE_W-1:0]  clr_val;

    always_comb begin
        cmd     = cmd_e'(word[FRAME_W-1 -: CMD_W]);
        addr    = word[DATA_W +: ADDR_W];
        data    = word[DATA_W-1:0];
        code    = data[DATA_W-1 -: CODE_W];
        pd_req  = |data;
        clr     = ~rst_n | ~reset_n;
        clr_val = rstsel ? MID_CODE : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rb_pend_q <= 1'b0;
            rb_sel_q  <= '0;
        end else if (exec && cmd == CMD_RB_SEL) begin
            rb_pend_q <= 1'b1;
            rb_sel_q  <= addr[NUM_CH-1:0];
        end else if (frame_start) begin
            rb_pend_q <= 1'b0;
        end
    end

    always_comb begin
        rb_code = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (rb_sel_q[i]) rb_code = in_codes[i*CODE_W +: CODE_W];
        end
        rb_word = {{(CMD_W + ADDR_W){1'b0}}, rb_code, {PAD_W{1'b0}}};
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic sel;
        assign sel = exec && addr[g];

        qdac_channel #(.CODE_W(CODE_W)) u_ch (
            .clk              (clk),
            .rst_n            (rst_n),
            .clr              (clr),
            .clr_val          (clr_val),
            .load_in          (sel && (cmd == CMD_WR_IN || cmd == CMD_WR_UPD)),
            .load_dac_direct  (sel && (cmd == CMD_WR_UPD || (cmd == CMD_WR_IN && ldac_low))),
            .load_dac_from_in ((sel && cmd == CMD_UPD) || ldac_fall),
            .pd_wr            (sel && cmd == CMD_PWR),
            .pd_val           (pd_req),
            .code_in          (code),
            .in_code          (in_codes[g*CODE_W +: CODE_W]),
            .dac_code         (dac_codes[g*CODE_W +: CODE_W]),
            .pd               (pd_state[g])
        );
    end

    assert_hold_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!exec && !ldac_fall && !clr) |=> ($stable(dac_codes) && $stable(pd_state)));

    assert_unused_cmd_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && !ldac_fall && !clr && cmd != CMD_WR_IN && cmd != CMD_UPD &&
         cmd != CMD_WR_UPD && cmd != CMD_PWR)
        |=> ($stable(dac_codes) && $stable(pd_state)));

    assert_ldac_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ldac_fall && !clr && !exec) |=> (dac_codes == $past(in_codes)));
endmodule

// File: tb/sim_quad_dac_serial_if.sv
module sim_quad_dac_serial_if;
    logic        clk = 1'b0;
    logic        rst_n, reset_n, rstsel, sync_n, sclk, sdin, ldac_n;
    logic        sdo;
    logic [39:0] dac_codes;
    logic [3:0]  pd_state;

    always #4 clk = ~clk;

    quad_dac_serial_if u0 (
        .clk(clk), .rst_n(rst_n), .reset_n(reset_n), .rstsel(rstsel),
        .sync_n(sync_n), .sclk(sclk), .sdin(sdin), .ldac_n(ldac_n),
        .sdo(sdo), .dac_codes(dac_codes), .pd_state(pd_state)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct packed {
        logic [15:0] tag;
        logic [23:0] w;
        logic        ldl;
        logic [39:0] exp;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{"R2", 24'h115540, 1'b0, {10'h000, 10'h000, 10'h000, 10'h000}},
        '{"R4", 24'h210000, 1'b0, {10'h000, 10'h000, 10'h000, 10'h155}},
        '{"R5", 24'h36FFC0, 1'b0, {10'h000, 10'h3FF, 10'h3FF, 10'h155}},
        '{"R3", 24'h182A80, 1'b1, {10'h0AA, 10'h3FF, 10'h3FF, 10'h155}},
        '{"R1", 24'h0F4440, 1'b0, {10'h0AA, 10'h3FF, 10'h3FF, 10'h155}},
        '{"R12",24'h7F8880, 1'b0, {10'h0AA, 10'h3FF, 10'h3FF, 10'h155}},
        '{"R2", 24'h1F0040, 1'b0, {10'h0AA, 10'h3FF, 10'h3FF, 10'h155}}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic [47:0] data, input int nbits, output logic [47:0] rx);
        rx = '0;
        sync_n = 1'b0;
        tick(4);
        for (int i = 0; i < nbits; i++) begin
            sdin = data[nbits-1-i];
            tick(2);
            rx = {rx[46:0], sdo};
            sclk = 1'b0;
            tick(4);
            sclk = 1'b1;
            tick(2);
        end
        tick(2);
        sync_n = 1'b1;
        tick(6);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R1 actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [47:0] rx;
        rst_n = 1'b0; reset_n = 1'b1; rstsel = 1'b0;
        sync_n = 1'b1; sclk = 1'b1; sdin = 1'b0; ldac_n = 1'b1;
        tick(5);
        rst_n = 1'b1;
        tick(3);
        // R9: power-on clear to zero scale
        chk("R9 codes", 64'(dac_codes), 64'h0);
        chk("R9 pd", 64'(pd_state), 64'h0);

        // R1 R2 R3 R4 R5 R12: table of frames and expected output codes
        for (int k = 0; k < NV; k++) begin
            ldac_n = ~VECS[k].ldl;
            xfer({24'h0, VECS[k].w}, 24, rx);
            ldac_n = 1'b1;
            tick(2);
            chk($sformatf("%s vec%0d", VECS[k].tag, k), 64'(dac_codes), 64'(VECS[k].exp));
        end

        // R6: load strobe fall copies all staging codes
        ldac_n = 1'b0;
        tick(4);
        chk("R6", 64'(dac_codes), 64'({4{10'h001}}));
        ldac_n = 1'b1;
        tick(2);

        // R7: power-down of channels 0 and 2, codes kept
        xfer(48'h450001, 24, rx);
        chk("R7 pd set", 64'(pd_state), 64'h5);
        chk("R7 codes kept", 64'(dac_codes), 64'({4{10'h001}}));
        xfer(48'h410000, 24, rx);
        chk("R7 pd clear", 64'(pd_state), 64'h4);

        // R8: 20-bit frame of a write-and-update is dropped
        xfer(48'h3F000, 20, rx);
        chk("R8", 64'(dac_codes), 64'({4{10'h001}}));

        // R10: readback of channel 1 staging code
        xfer(48'h920000, 24, rx);
        xfer(48'h000000, 24, rx);
        chk("R10", 64'(rx[23:0]), 64'h000040);

        // R11: 48-clock chained frame
        xfer({24'hABCDEF, 24'h313C00}, 48, rx);
        chk("R11 first half", 64'(rx[47:24]), 64'h000000);
        chk("R11 second half", 64'(rx[23:0]), 64'hABCDEF);
        chk("R11 last word run", 64'(dac_codes), 64'({10'h001, 10'h001, 10'h001, 10'h0F0}));

        // R9: reset pin with midscale select
        rstsel = 1'b1;
        reset_n = 1'b0;
        tick(3);
        reset_n = 1'b1;
        tick(2);
        chk("R9 midscale", 64'(dac_codes), 64'({4{10'h200}}));
        chk("R9 pd cleared", 64'(pd_state), 64'h0);
        xfer(48'h2F0000, 24, rx);
        chk("R9 staging cleared", 64'(dac_codes), 64'({4{10'h200}}));

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule